// File: doc/BRIEF.md
# RAM Self-Test Sequencer

A hardware test engine that exercises a single-port, word-addressed synchronous RAM with no processor involved. A start pulse launches three phases, always in the same order. The first is a walking-address, walking-data phase. For each address and data pair it writes the pattern, writes the pattern's complement one neighbour further on, then reads the first word back. The second phase checks address uniqueness: it fills the whole space with each word's own address and then verifies every word. The third phase fills the whole space with a cycle of three fixed words and then verifies it.

Progress and outcome appear on an 8-bit status code. The low seven bits name the phase that is running, and the top bit marks a failure. On the first compare mismatch the engine latches the failing address, the expected word and the raw word read. It then stops advancing and replays the failing access forever, so that the fault can be probed until reset. A valid-bit mask restricts the compare to the bits that the RAM really returns, as a tag store does when only its upper half-word is meaningful. The sweep can start at any word, and the distance to the neighbour is a parameter.

Top module: `ram_selftest_seq`

## Requirements
- R1: After reset, status_o is 0x00, done_o is 0 and mem_we_o is 0. No write is issued while the engine is idle or finished.
- R2: A start_i pulse taken while idle or finished runs the walking phase, then the uniqueness phase, then the three-word phase. While a phase runs, status_o[6:0] is CODE_BASE plus 0, 1 or 2 respectively (0x05, 0x06, 0x07 by default), and status_o[7] is 0 while no mismatch has been seen.
- R3: The walking phase visits the offsets 0, 1, 2, 4 and so on up to 2^(ADDR_W-1), added to BASE modulo the depth. At each address it applies 0, then 1<<k for k = 0 up to DATA_W-1.
- R4: Each walking pair takes four cycles: a write of the pattern, a write of its complement to (address + NBR_OFF) modulo the depth, a read of the address, and a compare cycle. Read data is valid one cycle after the read.
- R5: The uniqueness phase writes word BASE+w (modulo the depth) with its own word address, zero-extended, for w = 0 up to depth-1. It then reads and compares the words in the same order, taking two cycles per word.
- R6: The three-word phase writes the w-th word of the same sweep with PAT0, PAT1 or PAT2 according to w mod 3, and then verifies it in the same order.
- R7: Only the read bits set in VALID_MASK are compared. A difference in any other bit never counts as a mismatch.
- R8: A mismatch sets status_o[7], which then stays set until reset. It loads err_addr_o, err_exp_o and err_obs_o with the test address, the expected word and the raw word read, and done_o never rises in that run.
- R9: The error registers load only on the first mismatch, and later mismatches leave them unchanged. They are cleared by reset and by an accepted start.
- R10: After a mismatch in the walking phase, the engine repeats the same write, complement write, read and compare on the same address and data, forever.
- R11: After a mismatch in a fill phase, the engine repeats a read and compare of the failing address and issues no writes.
- R12: When all three phases pass, done_o goes high and status_o shows CODE_BASE+2 with bit 7 clear. Both hold, with no writes, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken while idle or finished |
| mem_addr_o | output | ADDR_W | RAM word address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_we_o | output | 1 | RAM write enable |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the read |
| status_o | output | 8 | {fail, phase code} |
| done_o | output | 1 | All phases passed |
| err_addr_o | output | ADDR_W | First failing address |
| err_exp_o | output | DATA_W | Expected word at the first failure |
| err_obs_o | output | DATA_W | Raw word read at the first failure |

## Verification
The bench builds two instances with ADDR_W=8, which keeps a full three-phase run near 2,700 cycles, so complete passing runs fit well inside the budget. One instance uses BASE=8, NBR_OFF=1 and a full mask. The shifted base lets the uniqueness and three-word sweeps wrap past the top of the space and back to word 0. The other uses BASE=0, NBR_OFF=4 and a mask of 0xFFFF0000. There the RAM model corrupts the low half-word on every read, which shows that masked bits are ignored, and a stuck upper bit in the three-word fill shows that unmasked bits are still compared.

// File: rtl/ram_selftest_pkg.sv
package ram_selftest_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WALK,
    PH_UNIQ,
    PH_TRIO,
    PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    ST_WR,
    ST_NB,
    ST_RD,
    ST_CMP
  } step_e;

endpackage

// File: rtl/ram_selftest_pat.sv
module ram_selftest_pat
  import ram_selftest_pkg::*;
#(
  parameter int unsigned          ADDR_W = 8,
  parameter int unsigned          DATA_W = 32,
  parameter int unsigned          BASE   = 0,
  parameter logic [DATA_W-1:0]    PAT0   = 32'hAAAA_AAAA,
  parameter logic [DATA_W-1:0]    PAT1   = 32'h5555_5555,
  parameter logic [DATA_W-1:0]    PAT2   = 32'hFFFF_0000,
  localparam int unsigned         AI_W   = $clog2(ADDR_W + 1),
  localparam int unsigned         PI_W   = $clog2(DATA_W + 1)
) (
  input  phase_e                  phase_i,
  input  logic [AI_W-1:0]         a_idx_i,
  input  logic [PI_W-1:0]         p_idx_i,
  input  logic [ADDR_W-1:0]       w_idx_i,
  input  logic [1:0]              trio_sel_i,
  output logic [ADDR_W-1:0]       taddr_o,
  output logic [DATA_W-1:0]       exp_o
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);
  localparam logic [DATA_W-1:0] ONE_D  = DATA_W'(1);

  logic [ADDR_W-1:0] walk_off, sweep_addr;
  logic [DATA_W-1:0] walk_data, trio_data;

  // offset 0 first, then 1<<(idx-1)
  assign walk_off   = (a_idx_i == '0) ? '0 : (ONE_A << (a_idx_i - AI_W'(1)));
  assign walk_data  = (p_idx_i == '0) ? '0 : (ONE_D << (p_idx_i - PI_W'(1)));
  assign sweep_addr = BASE_A + w_idx_i;

  always_comb begin
    unique case (trio_sel_i)
      2'd0:    trio_data = PAT0;
      2'd1:    trio_data = PAT1;
      default: trio_data = PAT2;
    endcase
  end

  always_comb begin
    unique case (phase_i)
      PH_WALK: begin
        taddr_o = BASE_A + walk_off;
        exp_o   = walk_data;
      end
      PH_UNIQ: begin
        taddr_o = sweep_addr;
        exp_o   = DATA_W'(sweep_addr);
      end
      default: begin
        taddr_o = sweep_addr;
        exp_o   = trio_data;
      end
    endcase
  end

endmodule

// File: rtl/ram_selftest_cap.sv
module ram_selftest_cap #(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter logic [DATA_W-1:0] VALID_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cmp_en_i,
  input  logic              first_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] obs_i,
  output logic              mismatch_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_obs_o
);

  logic held_q;

  assign mismatch_o = |((obs_i ^ exp_i) & VALID_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q     <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_obs_o  <= '0;
    end else if (clr_i) begin
      held_q     <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_obs_o  <= '0;
    end else if (cmp_en_i && first_i && mismatch_o && !held_q) begin
      held_q     <= 1'b1;
      err_addr_o <= addr_i;
      err_exp_o  <= exp_i;
      err_obs_o  <= obs_i;
    end
  end

  AST_CAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !clr_i) |=> ($stable(err_addr_o) && $stable(err_exp_o) && $stable(err_obs_o))); // R9

  AST_CAP_ONLY_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_q && !clr_i && !(cmp_en_i && mismatch_o)) |=> !held_q); // R8

endmodule

// File: rtl/ram_selftest_ctrl.sv
module ram_selftest_ctrl
  import ram_selftest_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NBR_OFF   = 1,
  parameter logic [6:0]  CODE_BASE = 7'h05,
  localparam int unsigned AI_W     = $clog2(ADDR_W + 1),
  localparam int unsigned PI_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mismatch_i,
  input  logic [ADDR_W-1:0] taddr_i,
  input  logic [DATA_W-1:0] exp_i,
  output phase_e            phase_o,
  output logic [AI_W-1:0]   a_idx_o,
  output logic [PI_W-1:0]   p_idx_o,
  output logic [ADDR_W-1:0] w_idx_o,
  output logic [1:0]        trio_sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              cmp_en_o,
  output logic              clr_o,
  output logic              fail_o,
  output logic              done_o,
  output logic [7:0]        status_o
);

  localparam logic [AI_W-1:0]   A_LAST = AI_W'(ADDR_W);
  localparam logic [PI_W-1:0]   P_LAST = PI_W'(DATA_W);
  localparam logic [ADDR_W-1:0] W_LAST = '1;
  localparam logic [ADDR_W-1:0] NBR_A  = ADDR_W'(NBR_OFF);

  phase_e            phase_q;
  step_e             step_q;
  logic              fill_q, fail_q;
  logic [AI_W-1:0]   a_q;
  logic [PI_W-1:0]   p_q;
  logic [ADDR_W-1:0] w_q;
  logic [1:0]        trio_q, trio_nx;
  logic              running, idle_like, miss;
  logic [6:0]        code;

  assign running   = (phase_q == PH_WALK) || (phase_q == PH_UNIQ) || (phase_q == PH_TRIO);
  assign idle_like = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
  assign trio_nx   = (trio_q == 2'd2) ? 2'd0 : trio_q + 2'd1;
  assign miss      = fail_q || mismatch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_WR;
      fill_q  <= 1'b1;
      fail_q  <= 1'b0;
      a_q     <= '0;
      p_q     <= '0;
      w_q     <= '0;
      trio_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE, PH_DONE: begin
          if (start_i) begin
            phase_q <= PH_WALK;
            step_q  <= ST_WR;
            fill_q  <= 1'b1;
            fail_q  <= 1'b0;
            a_q     <= '0;
            p_q     <= '0;
            w_q     <= '0;
            trio_q  <= '0;
          end
        end
        PH_WALK: begin
          unique case (step_q)
            ST_WR: step_q <= ST_NB;
            ST_NB: step_q <= ST_RD;
            ST_RD: step_q <= ST_CMP;
            default: begin
              step_q <= ST_WR;
              if (miss) begin
                fail_q <= 1'b1;        // replay same pair
              end else if (p_q == P_LAST) begin
                p_q <= '0;
                if (a_q == A_LAST) begin
                  phase_q <= PH_UNIQ;
                  fill_q  <= 1'b1;
                  w_q     <= '0;
                  trio_q  <= '0;
                end else begin
                  a_q <= a_q + AI_W'(1);
                end
              end else begin
                p_q <= p_q + PI_W'(1);
              end
            end
          endcase
        end
        default: begin // PH_UNIQ, PH_TRIO
          if (fill_q) begin
            if (w_q == W_LAST) begin
              fill_q <= 1'b0;
              w_q    <= '0;
              trio_q <= '0;
              step_q <= ST_RD;
            end else begin
              w_q    <= w_q + ADDR_W'(1);
              trio_q <= trio_nx;
            end
          end else if (step_q == ST_RD) begin
            step_q <= ST_CMP;
          end else begin
            step_q <= ST_RD;
            if (miss) begin
              fail_q <= 1'b1;          // re-read same word
            end else if (w_q == W_LAST) begin
              w_q     <= '0;
              trio_q  <= '0;
              fill_q  <= 1'b1;
              step_q  <= ST_WR;
              phase_q <= (phase_q == PH_UNIQ) ? PH_TRIO : PH_DONE;
            end else begin
              w_q    <= w_q + ADDR_W'(1);
              trio_q <= trio_nx;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_IDLE: code = 7'h00;
      PH_WALK: code = CODE_BASE;
      PH_UNIQ: code = CODE_BASE + 7'd1;
      default: code = CODE_BASE + 7'd2;
    endcase
  end

  assign mem_addr_o  = (step_q == ST_NB) ? taddr_i + NBR_A : taddr_i;
  assign mem_wdata_o = (step_q == ST_NB) ? ~exp_i : exp_i;
  assign mem_we_o    = running && ((step_q == ST_WR) || (step_q == ST_NB));
  assign cmp_en_o    = running && (step_q == ST_CMP);
  assign clr_o       = idle_like && start_i;
  assign fail_o      = fail_q;
  assign done_o      = (phase_q == PH_DONE);
  assign status_o    = {fail_q, code};
  assign phase_o     = phase_q;
  assign a_idx_o     = a_q;
  assign p_idx_o     = p_q;
  assign w_idx_o     = w_q;
  assign trio_sel_o  = trio_q;

  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_like |-> !mem_we_o); // R1

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> fail_q); // R8

  AST_LOOP_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> $stable(taddr_i) && $stable(exp_i)); // R10

  AST_FILL_LOOP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && phase_q != PH_WALK) |-> !mem_we_o); // R11

  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !status_o[7]); // R12

  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !cmp_en_o) |=> $stable(phase_q)); // R2

endmodule

// File: rtl/ram_selftest_seq.sv
module ram_selftest_seq
  import ram_selftest_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       BASE       = 0,
  parameter int unsigned       NBR_OFF    = 1,
  parameter logic [DATA_W-1:0] VALID_MASK = '1,
  parameter logic [6:0]        CODE_BASE  = 7'h05,
  parameter logic [DATA_W-1:0] PAT0       = 32'hAAAA_AAAA,
  parameter logic [DATA_W-1:0] PAT1       = 32'h5555_5555,
  parameter logic [DATA_W-1:0] PAT2       = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [7:0]        status_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_obs_o
);

  localparam int unsigned AI_W = $clog2(ADDR_W + 1);
  localparam int unsigned PI_W = $clog2(DATA_W + 1);

  phase_e            phase;
  logic [AI_W-1:0]   a_idx;
  logic [PI_W-1:0]   p_idx;
  logic [ADDR_W-1:0] w_idx, taddr;
  logic [1:0]        trio_sel;
  logic [DATA_W-1:0] exp_w;
  logic              mismatch, cmp_en, clr, fail;

  ram_selftest_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBR_OFF(NBR_OFF), .CODE_BASE(CODE_BASE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mismatch_i (mismatch),
    .taddr_i    (taddr),
    .exp_i      (exp_w),
    .phase_o    (phase),
    .a_idx_o    (a_idx),
    .p_idx_o    (p_idx),
    .w_idx_o    (w_idx),
    .trio_sel_o (trio_sel),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o),
    .cmp_en_o   (cmp_en),
    .clr_o      (clr),
    .fail_o     (fail),
    .done_o     (done_o),
    .status_o   (status_o)
  );

  ram_selftest_pat #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE),
    .PAT0(PAT0), .PAT1(PAT1), .PAT2(PAT2)
  ) u_pat (
    .phase_i   (phase),
    .a_idx_i   (a_idx),
    .p_idx_i   (p_idx),
    .w_idx_i   (w_idx),
    .trio_sel_i(trio_sel),
    .taddr_o   (taddr),
    .exp_o     (exp_w)
  );

  ram_selftest_cap #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VALID_MASK(VALID_MASK)
  ) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .cmp_en_i  (cmp_en),
    .first_i   (!fail),
    .addr_i    (taddr),
    .exp_i     (exp_w),
    .obs_i     (mem_rdata_i),
    .mismatch_o(mismatch),
    .err_addr_o(err_addr_o),
    .err_exp_o (err_exp_o),
    .err_obs_o (err_obs_o)
  );

endmodule

// File: tb/ram_selftest_seq_tb.sv
module ram_selftest_seq_tb_top;

  localparam int D = 256;
  localparam logic [31:0] P0 = 32'hAAAA_AAAA;
  localparam logic [31:0] P1 = 32'h5555_5555;
  localparam logic [31:0] P2 = 32'hFFFF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // device A: BASE 8, neighbour 1, full mask
  logic        d_start = 1'b0;
  logic [7:0]  d_addr, d_eaddr;
  logic [31:0] d_wdata, d_rdata, d_eexp, d_eobs;
  logic        d_we, d_done;
  logic [7:0]  d_status;

  // device B: BASE 0, neighbour 4, upper half valid
  logic        t_start = 1'b0;
  logic [7:0]  t_addr, t_eaddr;
  logic [31:0] t_wdata, t_rdata, t_eexp, t_eobs;
  logic        t_we, t_done;
  logic [7:0]  t_status;

  ram_selftest_seq #(.ADDR_W(8), .DATA_W(32), .BASE(8), .NBR_OFF(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(d_start),
    .mem_addr_o(d_addr), .mem_wdata_o(d_wdata), .mem_we_o(d_we), .mem_rdata_i(d_rdata),
    .status_o(d_status), .done_o(d_done),
    .err_addr_o(d_eaddr), .err_exp_o(d_eexp), .err_obs_o(d_eobs));

  ram_selftest_seq #(.ADDR_W(8), .DATA_W(32), .BASE(0), .NBR_OFF(4),
                     .VALID_MASK(32'hFFFF_0000)) tag_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(t_start),
    .mem_addr_o(t_addr), .mem_wdata_o(t_wdata), .mem_we_o(t_we), .mem_rdata_i(t_rdata),
    .status_o(t_status), .done_o(t_done),
    .err_addr_o(t_eaddr), .err_exp_o(t_eexp), .err_obs_o(t_eobs));

  // RAM models with fault hooks
  logic [31:0] mem0 [D];
  logic [31:0] mem1 [D];
  logic        stuck_on = 1'b0, alias_on = 1'b0, junk_on = 1'b0, hi_stuck_on = 1'b0;
  logic [31:0] extra = 32'h0;

  always @(posedge clk) begin
    if (d_we) begin
      mem0[d_addr] <= d_wdata;
      if (alias_on && d_addr == 8'h31) mem0[8'h30] <= d_wdata;
    end
    d_rdata <= (stuck_on && d_addr == 8'h0C) ? ((mem0[d_addr] & ~32'h8) | extra) : mem0[d_addr];
  end

  always @(posedge clk) begin
    if (t_we) mem1[t_addr] <= t_wdata;
    if (junk_on)
      t_rdata <= {mem1[t_addr][31:16], mem1[t_addr][15:0] ^ 16'hBEEF};
    else if (hi_stuck_on && t_addr == 8'h22)
      t_rdata <= mem1[t_addr] & ~32'h0010_0000;
    else
      t_rdata <= mem1[t_addr];
  end

  // bench selection of the device under stream comparison
  logic        sel = 1'b0;
  logic        s_we, s_done;
  logic [7:0]  s_addr, s_status;
  logic [31:0] s_wdata;
  assign s_we     = sel ? t_we     : d_we;
  assign s_addr   = sel ? t_addr   : d_addr;
  assign s_wdata  = sel ? t_wdata  : d_wdata;
  assign s_status = sel ? t_status : d_status;
  assign s_done   = sel ? t_done   : d_done;

  // expected per-cycle port activity
  bit          we_q[$];
  logic [7:0]  ad_q[$];
  logic [31:0] wd_q[$];
  bit          ac_q[$];
  int          ph_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input bit we, input int ad, input logic [31:0] wd, input bit ac, input int ph);
    we_q.push_back(we); ad_q.push_back(8'(ad)); wd_q.push_back(wd);
    ac_q.push_back(ac); ph_q.push_back(ph);
  endtask

  function automatic logic [31:0] trio(input int w);
    case (w % 3)
      0: return P0;
      1: return P1;
      default: return P2;
    endcase
  endfunction

  task automatic build(input int base, input int nbr);
    we_q.delete(); ad_q.delete(); wd_q.delete(); ac_q.delete(); ph_q.delete();
    for (int a = 0; a <= 8; a++) begin
      int off = (a == 0) ? 0 : (1 << (a - 1));
      int ad = (base + off) % D;
      for (int p = 0; p <= 32; p++) begin
        logic [31:0] dv = (p == 0) ? 32'h0 : (32'h1 << (p - 1));
        push(1, ad, dv, 1, 0);
        push(1, (ad + nbr) % D, ~dv, 1, 0);
        push(0, ad, 32'h0, 1, 0);
        push(0, ad, 32'h0, 0, 0);
      end
    end
    for (int w = 0; w < D; w++) push(1, (base + w) % D, 32'((base + w) % D), 1, 1);
    for (int w = 0; w < D; w++) begin
      push(0, (base + w) % D, 32'h0, 1, 1);
      push(0, (base + w) % D, 32'h0, 0, 1);
    end
    for (int w = 0; w < D; w++) push(1, (base + w) % D, trio(w), 1, 2);
    for (int w = 0; w < D; w++) begin
      push(0, (base + w) % D, 32'h0, 1, 2);
      push(0, (base + w) % D, 32'h0, 0, 2);
    end
  endtask

  task automatic pulse_start(input bit which);
    @(negedge clk);
    if (which) t_start = 1'b1; else d_start = 1'b1;
    @(negedge clk);
    t_start = 1'b0; d_start = 1'b0;
  endtask

  task automatic run_stream(input bit which);
    string nm;
    sel = which;
    pulse_start(which);
    for (int i = 0; i < we_q.size(); i++) begin
      nm = (ph_q[i] == 0) ? "R3/R4 walk" : (ph_q[i] == 1) ? "R5 uniq" : "R6 trio";
      if (which) nm = {nm, " R7 masked"};
      chk({nm, " we"}, 32'(s_we), 32'(we_q[i]));
      if (ac_q[i]) chk({nm, " addr"}, 32'(s_addr), 32'(ad_q[i]));
      if (we_q[i]) chk({nm, " wdata"}, s_wdata, wd_q[i]);
      chk("R2 status code", 32'(s_status), 32'(8'h05 + 8'(ph_q[i])));
      @(negedge clk);
    end
    chk("R12 done", 32'(s_done), 32'h1);
    chk("R12 status", 32'(s_status), 32'h07);
    repeat (3) @(negedge clk);
    chk("R12 done holds", 32'(s_done), 32'h1);
    chk("R12 no write when finished", 32'(s_we), 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_fail(input bit which, input string req);
    int n = 0;
    sel = which;
    while (!s_status[7] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " failure seen"}, 32'(s_status[7]), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int wcnt, bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status A", 32'(d_status), 32'h0);
    chk("R1 done A", 32'(d_done), 32'h0);
    chk("R1 we A", 32'(d_we), 32'h0);
    chk("R1 status B", 32'(t_status), 32'h0);
    chk("R1 we B", 32'(t_we), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle no write", 32'(d_we), 32'h0);

    // run A: clean RAM, full stream comparison
    build(8, 1);
    run_stream(1'b0);
    for (int w = 0; w < D; w++) chk("R6 final fill", mem0[(8 + w) % D], trio(w));
    chk("R9 capture clear after pass", d_eaddr, 8'h0);

    // run B: bit 3 stuck low at word 0x0C
    do_reset();
    stuck_on = 1'b1;
    extra = 32'h0;
    pulse_start(1'b0);
    wait_fail(1'b0, "R8 walk");
    chk("R8 status walk fail", 32'(d_status), 32'h85);
    chk("R8 done low", 32'(d_done), 32'h0);
    chk("R8 err addr", 32'(d_eaddr), 32'h0C);
    chk("R8 err exp", d_eexp, 32'h8);
    chk("R8 err obs", d_eobs, 32'h0);
    extra = 32'h100;
    wcnt = 0; bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (d_we) begin
        wcnt++;
        if (!((d_addr == 8'h0C && d_wdata == 32'h8) || (d_addr == 8'h0D && d_wdata == ~32'h8))) bad++;
      end else if (d_addr != 8'h0C) bad++;
    end
    chk("R10 replay write count", 32'(wcnt), 32'd20);
    chk("R10 replay same pair", 32'(bad), 32'd0);
    chk("R9 obs held", d_eobs, 32'h0);
    chk("R9 addr held", 32'(d_eaddr), 32'h0C);
    chk("R8 fail sticky", 32'(d_status), 32'h85);

    // run C: write to 0x31 also lands in 0x30
    do_reset();
    chk("R9 capture cleared by reset", 32'(d_eaddr), 32'h0);
    stuck_on = 1'b0;
    alias_on = 1'b1;
    pulse_start(1'b0);
    wait_fail(1'b0, "R5 uniq");
    chk("R5 status uniq fail", 32'(d_status), 32'h86);
    chk("R5 err addr", 32'(d_eaddr), 32'h30);
    chk("R5 err exp", d_eexp, 32'h30);
    chk("R5 err obs", d_eobs, 32'h31);
    wcnt = 0; bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (d_we) wcnt++;
      if (d_addr != 8'h30) bad++;
    end
    chk("R11 no writes in loop", 32'(wcnt), 32'd0);
    chk("R11 loop address", 32'(bad), 32'd0);
    alias_on = 1'b0;

    // run D: low half-word garbage on masked device
    do_reset();
    junk_on = 1'b1;
    build(0, 4);
    run_stream(1'b1);
    junk_on = 1'b0;

    // run E: upper bit 20 stuck low at word 0x22
    do_reset();
    hi_stuck_on = 1'b1;
    pulse_start(1'b1);
    wait_fail(1'b1, "R7 trio");
    chk("R7 status trio fail", 32'(t_status), 32'h87);
    chk("R7 err addr", 32'(t_eaddr), 32'h22);
    chk("R6 err exp", t_eexp, P1);
    chk("R7 err obs raw", t_eobs, 32'h5545_5555);
    chk("R8 done low B", 32'(t_done), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule